// File: doc/BRIEF.md
# Fixed-Point 8x8 Forward DCT Engine

This block turns an 8x8 tile of signed 16-bit samples into 64 forward DCT coefficients. The results match, bit for bit, an integer reference that works in 16-bit lanes. A producer delivers the tile one row per beat over a valid/ready handshake. Each beat carries eight samples, and lane c (bits 16c+15 down to 16c) holds column c. The engine scales each sample up by four. It then runs a single 8-point 1-D transform eight times per pass, with the tile transposed between passes, for exactly two passes. Last, it halves every coefficient, rounding toward zero.

The output also uses eight lanes per beat. Beat r is coefficient row r (vertical frequency r), and lane k is horizontal frequency k. The output valid is held, and the data stays frozen, until the consumer takes the beat. A new tile is accepted only after all eight output rows have drained.

Top module: `fdct8x8_core`

## Requirements
- R1: After reset, inReady is 1 and outValid is 0.
- R2: Exactly eight input beats are accepted per tile. After the eighth, inReady stays 0 until the tile's output has drained, and inReady and outValid are never 1 together.
- R3: Each sample is shifted left by two before the transform and wraps to 16 bits. A tile of all 32767 therefore gives a DC coefficient (row 0, lane 0) of -65, the same as a tile of all -1.
- R4: All 64 coefficients of any tile equal the two-pass integer reference. The reference uses a 14-bit rounding shift (offset 8192) after every product, 16-bit narrowing, and constants 16069, 15137, 13623, 11585, 9102, 6270 and 3196 for cos(k·pi/16), k = 1..7.
- R5: For a tile of one constant value, every coefficient except row 0 lane 0 is zero.
- R6: The final halving rounds toward zero. A tile of all -2 gives a pre-halving DC of -255 and an output DC of -127.
- R7: Input beat r, lane c is sample (r,c). Output beat r, lane k is coefficient (r,k). Lane i occupies bits 16i+15:16i.
- R8: While outValid is 1 and outReady is 0, outValid stays 1 and outRow does not change.
- R9: outValid rises exactly 16 clock cycles after the edge that accepts the eighth input row.
- R10: The edge that takes the eighth output row returns the block to accepting input (inReady 1, outValid 0).
- R11: Every 16-bit add and subtract in the transform wraps in two's complement. Full-scale alternating tiles match the reference exactly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input row offered |
| inReady | output | 1 | Engine can take an input row |
| inRow | input | 128 | Eight signed 16-bit samples, lane c = column c |
| outValid | output | 1 | Output coefficient row available |
| outReady | input | 1 | Consumer takes the output row |
| outRow | output | 128 | Eight signed 16-bit coefficients, lane k = frequency k |

## Verification
Some properties are checked on every cycle. These are the handshake rules: input and output are never offered together, the three write strobes are mutually exclusive, stalled output stays frozen, and the engine goes back to loading after the last row drains. The fixed 16-cycle gap from the last input row to the first output row is also checked each cycle, using a counter. Arithmetic correctness can only be shown by the scenarios, which compare whole tiles against an independent integer model. The scenarios cover random tiles, constant tiles, tiles whose pre-scale wraps, and full-scale checkerboards that overflow intermediate sums. They also include a DC value whose halving lands on an odd negative number.

// File: rtl/fdct_pkg.sv
`timescale 1ns/1ps
package fdct_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int POINTS    = 8;
  localparam int IDX_W     = $clog2(POINTS);
  localparam int VEC_W     = POINTS * SAMPLE_W;
  localparam int FRAC_BITS = 14;
  localparam int PRESCALE  = 2;
  localparam int PROD_W    = 2 * SAMPLE_W + 2;
  localparam int LATENCY   = 2 * POINTS;

  typedef logic signed [SAMPLE_W-1:0] sample_t;
  typedef logic signed [PROD_W-1:0]   prod_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             loadWr;
    logic             passOne;
    logic             passTwo;
    logic [IDX_W-1:0] idx;
  } strobe_t;

  // cos(k*pi/16) scaled by 2^14
  localparam prod_t KC1 = 16069;
  localparam prod_t KC2 = 15137;
  localparam prod_t KC3 = 13623;
  localparam prod_t KC4 = 11585;
  localparam prod_t KC5 = 9102;
  localparam prod_t KC6 = 6270;
  localparam prod_t KC7 = 3196;
  localparam prod_t ROUND_OFS = prod_t'(1) <<< (FRAC_BITS - 1);

  function automatic prod_t widen(sample_t v);
    return prod_t'(v);
  endfunction

  function automatic sample_t roundNarrow(prod_t p);
    prod_t t;
    t = (p + ROUND_OFS) >>> FRAC_BITS;
    return t[SAMPLE_W-1:0];
  endfunction

  function automatic sample_t halveTowardZero(sample_t n);
    logic signed [SAMPLE_W:0] t;
    t = {n[SAMPLE_W-1], n} + {{SAMPLE_W{1'b0}}, n[SAMPLE_W-1]};
    return t[SAMPLE_W:1];
  endfunction
endpackage

// File: rtl/fdct_butterfly.sv
`timescale 1ns/1ps
module fdct_butterfly
  import fdct_pkg::*;
(
  input  sample_t [POINTS-1:0] xIn,
  output sample_t [POINTS-1:0] yOut
);
  sample_t x [POINTS];
  sample_t s0, s1, s2, s3, s4, s5, s6, s7;
  sample_t e0, e1, e2, e3;
  sample_t diff65, sum65, rotA, rotB;
  sample_t o0, o1, o2, o3;

  always_comb begin
    for (int i = 0; i < POINTS; i++) x[i] = xIn[i];
    // first stage: mirrored sums and differences, 16-bit wrap (R11)
    s0 = x[0] + x[7];
    s1 = x[1] + x[6];
    s2 = x[2] + x[5];
    s3 = x[3] + x[4];
    s4 = x[3] - x[4];
    s5 = x[2] - x[5];
    s6 = x[1] - x[6];
    s7 = x[0] - x[7];
    // even half
    e0 = s0 + s3;
    e1 = s1 + s2;
    e2 = s1 - s2;
    e3 = s0 - s3;
    yOut[0] = roundNarrow((widen(e0) + widen(e1)) * KC4);
    yOut[4] = roundNarrow((widen(e0) - widen(e1)) * KC4);
    yOut[2] = roundNarrow(widen(e2) * KC6 + widen(e3) * KC2);
    yOut[6] = roundNarrow(widen(e3) * KC6 - widen(e2) * KC2);
    // odd half: pi/4 rotation, then butterflies
    diff65 = s6 - s5;
    sum65  = s6 + s5;
    rotA   = roundNarrow(widen(diff65) * KC4);
    rotB   = roundNarrow(widen(sum65) * KC4);
    o0 = s4 + rotA;
    o1 = s4 - rotA;
    o2 = s7 - rotB;
    o3 = s7 + rotB;
    yOut[1] = roundNarrow(widen(o3) * KC1 + widen(o0) * KC7);
    yOut[5] = roundNarrow(widen(o1) * KC3 + widen(o2) * KC5);
    yOut[3] = roundNarrow(widen(o2) * KC3 - widen(o1) * KC5);
    yOut[7] = roundNarrow(widen(o3) * KC7 - widen(o0) * KC1);
  end
endmodule

// File: rtl/fdct_datapath.sv
`timescale 1ns/1ps
module fdct_datapath
  import fdct_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [VEC_W-1:0] inRow,
  output logic [VEC_W-1:0] outRow
);
  // tileA: loaded transposed, later holds the final result; tileB: between passes
  sample_t tileA [POINTS][POINTS];
  sample_t tileB [POINTS][POINTS];
  sample_t [POINTS-1:0] engineIn;
  sample_t [POINTS-1:0] engineOut;

  always_comb begin
    for (int k = 0; k < POINTS; k++)
      engineIn[k] = stb.passOne ? tileA[stb.idx][k] : tileB[stb.idx][k];
  end

  fdct_butterfly uEngine (.xIn(engineIn), .yOut(engineOut));

  always_ff @(posedge clk) begin
    if (stb.loadWr) begin
      for (int r = 0; r < POINTS; r++)
        tileA[r][stb.idx] <= {inRow[r*SAMPLE_W +: SAMPLE_W-PRESCALE], {PRESCALE{1'b0}}};
    end else if (stb.passTwo) begin
      for (int k = 0; k < POINTS; k++)
        tileA[stb.idx][k] <= engineOut[k];
    end
    if (stb.passOne) begin
      for (int k = 0; k < POINTS; k++)
        tileB[k][stb.idx] <= engineOut[k];
    end
  end

  always_comb begin
    for (int k = 0; k < POINTS; k++)
      outRow[k*SAMPLE_W +: SAMPLE_W] = halveTowardZero(tileA[stb.idx][k]);
  end

  // R2: at most one writer of the tile store per cycle
  assert_one_writer_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadWr, stb.passOne, stb.passTwo}));
endmodule

// File: rtl/fdct_ctrl.sv
`timescale 1ns/1ps
module fdct_ctrl
  import fdct_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output logic    inReady,
  output logic    outValid,
  input  logic    outReady,
  output strobe_t stb
);
  typedef enum logic [1:0] {ST_LOAD, ST_PASS1, ST_PASS2, ST_EMIT} state_t;
  localparam int CNT_W = $clog2(LATENCY + 2);

  state_t           state;
  logic [IDX_W-1:0] idx;
  logic             lastIdx;

  assign lastIdx = (idx == IDX_W'(POINTS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_LOAD;
      idx   <= '0;
    end else begin
      case (state)
        ST_LOAD: if (inValid) begin
          idx <= idx + 1'b1;
          if (lastIdx) state <= ST_PASS1;
        end
        ST_PASS1: begin
          idx <= idx + 1'b1;
          if (lastIdx) state <= ST_PASS2;
        end
        ST_PASS2: begin
          idx <= idx + 1'b1;
          if (lastIdx) state <= ST_EMIT;
        end
        default: if (outReady) begin
          idx <= idx + 1'b1;
          if (lastIdx) state <= ST_LOAD;
        end
      endcase
    end
  end

  always_comb begin
    inReady     = (state == ST_LOAD);
    outValid    = (state == ST_EMIT);
    stb.loadWr  = inReady && inValid;
    stb.passOne = (state == ST_PASS1);
    stb.passTwo = (state == ST_PASS2);
    stb.idx     = idx;
  end

  // cycle counter since the last input row, used by the latency check
  logic [CNT_W-1:0] sinceLoad;
  always_ff @(posedge clk) begin
    if (!rstN) sinceLoad <= CNT_W'(LATENCY + 1);
    else if (stb.loadWr && lastIdx) sinceLoad <= '0;
    else if (sinceLoad != CNT_W'(LATENCY + 1)) sinceLoad <= sinceLoad + 1'b1;
  end

  assert_no_overlap_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(inReady && outValid));
  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> sinceLoad == CNT_W'(LATENCY));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(stb.idx)));
  assert_return_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && lastIdx) |=> (inReady && !outValid));
endmodule

// File: rtl/fdct8x8_core.sv
`timescale 1ns/1ps
module fdct8x8_core
  import fdct_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [VEC_W-1:0] inRow,
  output logic             outValid,
  input  logic             outReady,
  output logic [VEC_W-1:0] outRow
);
  strobe_t stb;

  fdct_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .stb(stb)
  );

  fdct_datapath uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .inRow(inRow), .outRow(outRow)
  );

  assert_data_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(outRow));
endmodule

// File: tb/tb_fdct8x8_core.sv
`timescale 1ns/1ps
module tb_fdct8x8_core;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rstN, inValid, inReady, outValid, outReady;
  logic [127:0] inRow, outRow;

  fdct8x8_core dut (.clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
                    .inRow(inRow), .outValid(outValid), .outReady(outReady),
                    .outRow(outRow));

  int checks = 0;
  int failures = 0;
  int tile [8][8];
  int expv [8][8];
  int got  [8][8];
  int unsigned lcg = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input string what,
                       input longint actual, input longint expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, actual, expected);
    end
  endtask

  function automatic int w16(input int v);
    logic signed [15:0] t;
    t = v[15:0];
    return int'(t);
  endfunction

  function automatic int rnd(input longint p);
    longint t;
    t = (p + 8192) >>> 14;
    return w16(int'(t));
  endfunction

  function automatic int halve(input int n);
    return (n < 0) ? -((-n) / 2) : n / 2;
  endfunction

  function automatic void dct1d(input int x[8], output int y[8]);
    int s[8]; int e0, e1, e2, e3, ra, rb, o0, o1, o2, o3;
    s[0] = w16(x[0] + x[7]); s[1] = w16(x[1] + x[6]);
    s[2] = w16(x[2] + x[5]); s[3] = w16(x[3] + x[4]);
    s[4] = w16(x[3] - x[4]); s[5] = w16(x[2] - x[5]);
    s[6] = w16(x[1] - x[6]); s[7] = w16(x[0] - x[7]);
    e0 = w16(s[0] + s[3]); e1 = w16(s[1] + s[2]);
    e2 = w16(s[1] - s[2]); e3 = w16(s[0] - s[3]);
    y[0] = rnd(longint'(e0 + e1) * 11585);
    y[4] = rnd(longint'(e0 - e1) * 11585);
    y[2] = rnd(longint'(e2) * 6270 + longint'(e3) * 15137);
    y[6] = rnd(longint'(e3) * 6270 - longint'(e2) * 15137);
    ra = rnd(longint'(w16(s[6] - s[5])) * 11585);
    rb = rnd(longint'(w16(s[6] + s[5])) * 11585);
    o0 = w16(s[4] + ra); o1 = w16(s[4] - ra);
    o2 = w16(s[7] - rb); o3 = w16(s[7] + rb);
    y[1] = rnd(longint'(o3) * 16069 + longint'(o0) * 3196);
    y[5] = rnd(longint'(o1) * 13623 + longint'(o2) * 9102);
    y[3] = rnd(longint'(o2) * 13623 - longint'(o1) * 9102);
    y[7] = rnd(longint'(o3) * 3196 - longint'(o0) * 16069);
  endfunction

  // two column passes with transposes, then halving
  function automatic void refModel();
    int a[8][8]; int u[8][8]; int col[8]; int y[8];
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) a[i][j] = w16(tile[i][j] * 4);
    for (int j = 0; j < 8; j++) begin
      for (int i = 0; i < 8; i++) col[i] = a[i][j];
      dct1d(col, y);
      for (int k = 0; k < 8; k++) u[j][k] = y[k];
    end
    for (int j = 0; j < 8; j++) begin
      for (int i = 0; i < 8; i++) col[i] = u[i][j];
      dct1d(col, y);
      for (int k = 0; k < 8; k++) expv[j][k] = halve(y[k]);
    end
  endfunction

  function automatic int nextRand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return w16(int'(lcg >> 16));
  endfunction

  // load a tile, wait for the result, drain with optional stalls
  task automatic runTile(input string tag, input bit stall);
    int lat; int rowsGot; int cyc; logic [127:0] held; bit heldValid;
    refModel();
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      while (!inReady) @(negedge clk);
      for (int c = 0; c < 8; c++) inRow[16*c +: 16] = tile[r][c][15:0];
      inValid = 1'b1;
    end
    @(negedge clk);
    inValid = 1'b0;
    check(inReady == 1'b0, "R2", "inReady after eighth row", inReady, 0);
    lat = 0;
    while (!outValid && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 16, "R9", "cycles to first output", lat, 16);
    rowsGot = 0; cyc = 0; heldValid = 0; held = '0;
    while (rowsGot < 8 && cyc < 200) begin
      if (heldValid)
        check(outRow == held && outValid, "R8", "stalled row changed", 0, 1);
      outReady = stall ? (cyc % 3 == 2) : 1'b1;
      if (outValid && outReady) begin
        bit ok; ok = 1'b1;
        for (int k = 0; k < 8; k++) begin
          got[rowsGot][k] = w16(int'(outRow[16*k +: 16]));
          if (got[rowsGot][k] != expv[rowsGot][k]) begin
            ok = 1'b0;
            $display("FAIL %s row %0d lane %0d: got %0d expected %0d", tag, rowsGot, k,
                     got[rowsGot][k], expv[rowsGot][k]);
          end
        end
        checks++;
        if (!ok) failures++;
        rowsGot++;
        heldValid = 0;
      end else if (outValid) begin
        held = outRow;
        heldValid = 1;
      end
      cyc++;
      @(negedge clk);
    end
    outReady = 1'b0;
    check(inReady && !outValid, "R10", "ready for next tile", {inReady, outValid}, 2);
  endtask

  task automatic testReset();
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b0; inRow = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1", "inReady after reset", inReady, 1);
    check(outValid == 1'b0, "R1", "outValid after reset", outValid, 0);
  endtask

  task automatic testRandom();
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) tile[i][j] = nextRand();
      runTile("R4/R7 random", 1'b0);
    end
    // small-range tile: position-sensitive ordering check
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) tile[i][j] = (i == 1 && j == 6) ? 300 : 0;
    runTile("R7 impulse", 1'b0);
  endtask

  task automatic testConstant();
    int vals[2] = '{100, -2};
    foreach (vals[v]) begin
      bit acZero; acZero = 1'b1;
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++) tile[i][j] = vals[v];
      runTile("R5 constant", 1'b0);
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          if ((i != 0 || j != 0) && got[i][j] != 0) acZero = 1'b0;
      check(acZero, "R5", "non-DC coefficients zero", acZero, 1);
    end
    check(got[0][0] == -127, "R6", "DC of all -2 tile", got[0][0], -127);
  endtask

  task automatic testWrap();
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) tile[i][j] = 32767;
    runTile("R3 prescale wrap", 1'b0);
    check(got[0][0] == -65, "R3", "DC of all 32767 tile", got[0][0], -65);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) tile[i][j] = ((i + j) % 2 == 1) ? -32768 : 32767;
    runTile("R11 checkerboard", 1'b0);
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) tile[i][j] = (j % 2 == 1) ? -32768 : 8191;
    runTile("R11 column stripes", 1'b0);
  endtask

  task automatic testBackpressure();
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) tile[i][j] = nextRand();
    runTile("R8 stalled drain", 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog: got hang expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    testReset();
    testRandom();
    testConstant();
    testWrap();
    testBackpressure();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule